// File: doc/BRIEF.md
# Quad Down-Counting Timer

This block holds four independent down-counters behind a 32-bit register interface, plus one shared interrupt line. Software programs a counter by writing its start value, choosing a prescale ratio, a 16-bit or 32-bit width and a wrap behaviour, and then setting its enable bit. Each counter then drops by one on every prescaled tick. The tick comes from the `tick_en` input, which qualifies the bus clock.

When a counter reaches zero it raises its own raw status bit. The next tick at zero then does one of three things:

- In free-running mode the counter wraps to all ones.
- In periodic mode it reloads from a background register. Writes to that register never disturb a count already in progress.
- In one-shot mode it parks at zero.

The interrupt output is high while any raw status bit is set whose mask bit is also set.

The register port is a plain single-cycle access with no back-pressure. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high. Reads have no side effects.

Top module: `quad_down_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Address map, by byte address:
  - Shared registers: 0x00 is the mask (read/write), 0x04 is raw status, 0x08 is masked status and 0x0C is the clear register.
  - Counter n owns 0x10+0x10*n. Within that window, +0x0 is the start value, +0x4 is the live count, +0x8 is the control word and +0xC is the background value.
  - The start, control, background and mask registers read back what was written. Control bits 5:4 and 31:8 read zero.
  - Writes to the raw-status and masked-status addresses are ignored.
- R3: A write to the start-value register places the value in the live count at that clock edge. It also restarts the prescaler phase, so a full prescale period passes before the next decrement.
- R4: The live count decrements once per prescaled tick only when control bit 7 (enable) is 1 and `tick_en` is high. Otherwise it holds its value.
- R5: Control bits 3:2 set the prescaler: 00 divides by 1, 01 divides by 16, and both 10 and 11 divide by 256.
- R6: When control bit 1 is 0, only the low 16 bits count, the live count reads with bits 31:16 zero, and it wraps from 0 to 0x0000FFFF. When bit 1 is 1, all 32 bits count.
- R7: Free-running mode (bit 6 = 0, bit 0 = 0): a tick at zero loads the maximum value for the width.
- R8: Periodic mode (bit 6 = 1, bit 0 = 0): a tick at zero loads the background value. Writing the background value leaves the live count unchanged.
- R9: One-shot mode (bit 0 = 1, whatever bit 6 is): the count stays at zero after reaching it, and no further status events occur.
- R10: Raw status bit n sets at the edge where counter n steps from 1 to 0. It stays set until a write of 1 to bit n of the clear register. A set and a clear in the same cycle leave the bit set.
- R11: Masked status is raw status AND mask. `irq` is high exactly when masked status is non-zero.
- R12: Counters are independent: writes to one counter and the ticks it receives do not change another counter's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count qualifier; one raw tick per high cycle |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | OR of masked status bits |

## Verification
The counters are driven through each wrap mode from small start values, so that the step from 1 to 0 and the step taken at zero both land on known tick counts:

- A free-running counter shows all ones after the zero.
- A periodic counter shows its background value after the zero.
- A one-shot counter stays at zero.

This tells the three modes apart on a single read. Prescaler runs stop one raw tick before the expected decrement and then take one more tick, which separates divide-by-16 from divide-by-256 and from an off-by-one phase. A load written halfway through a prescale period shows whether the phase restarts. Status tests collide a clear with an expiry in the same cycle, and they toggle the mask, to distinguish a set-wins clear from a clear-wins one and a masked line from a raw one.

// File: rtl/qtmr_pkg.sv
`timescale 1ns/1ps
package qtmr_pkg;

  // Word index (bus_addr[3:2]) inside the shared block
  localparam logic [1:0] SH_MASK = 2'd0;
  localparam logic [1:0] SH_RAW  = 2'd1;
  localparam logic [1:0] SH_MIS  = 2'd2;
  localparam logic [1:0] SH_CLR  = 2'd3;

  // Word index inside a counter window
  localparam logic [1:0] CW_START = 2'd0;
  localparam logic [1:0] CW_LIVE  = 2'd1;
  localparam logic [1:0] CW_CTRL  = 2'd2;
  localparam logic [1:0] CW_BACK  = 2'd3;

  typedef enum logic [1:0] {
    PS_DIV1    = 2'b00,
    PS_DIV16   = 2'b01,
    PS_DIV256  = 2'b10,
    PS_DIV256X = 2'b11
  } pre_e;

  typedef struct packed {
    logic en;
    logic periodic;
    pre_e pre;
    logic wide;
    logic oneshot;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.en       = w[7];
    c.periodic = w[6];
    c.pre      = pre_e'(w[3:2]);
    c.wide     = w[1];
    c.oneshot  = w[0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    return {24'b0, c.en, c.periodic, 2'b00, c.pre, c.wide, c.oneshot};
  endfunction

endpackage

// File: rtl/qtmr_prescale.sv
`timescale 1ns/1ps
module qtmr_prescale #(
  parameter int PS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  qtmr_pkg::pre_e    sel,
  output logic              step
);
  import qtmr_pkg::*;

  localparam logic [PS_W-1:0] LIM_1   = '0;
  localparam logic [PS_W-1:0] LIM_16  = PS_W'(15);
  localparam logic [PS_W-1:0] LIM_256 = PS_W'(255);

  logic [PS_W-1:0] phase_q;
  logic [PS_W-1:0] limit;

  always_comb begin
    case (sel)
      PS_DIV1:  limit = LIM_1;
      PS_DIV16: limit = LIM_16;
      default:  limit = LIM_256;
    endcase
  end

  assign step = run && (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= step ? '0 : phase_q + PS_W'(1);
    end
  end

endmodule

// File: rtl/qtmr_channel.sv
`timescale 1ns/1ps
module qtmr_channel #(
  parameter int DW   = 32,
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            wr_start,
  input  logic            wr_ctrl,
  input  logic            wr_back,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   start_q,
  output logic [DW-1:0]   back_q,
  output logic [DW-1:0]   live,
  output qtmr_pkg::ctrl_t ctrl_q,
  output logic            expire
);
  import qtmr_pkg::*;

  localparam int NW = DW / 2;

  logic [DW-1:0] cur_q;
  logic          step;
  logic          at_zero;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic wide);
    return wide ? v : {{(DW-NW){1'b0}}, v[NW-1:0]};
  endfunction

  assign live    = fit(cur_q, ctrl_q.wide);
  assign at_zero = (live == '0);
  assign expire  = step && (live == DW'(1));

  qtmr_prescale #(.PS_W(PS_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_start),
    .run     (ctrl_q.en && tick_en && !wr_start),
    .sel     (ctrl_q.pre),
    .step    (step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      back_q  <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_start) start_q <= wdata;
      if (wr_back)  back_q  <= wdata;
      if (wr_ctrl)  ctrl_q  <= ctrl_from_word(32'(wdata));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (wr_start) begin
      cur_q <= wdata;
    end else if (step) begin
      if (!at_zero)          cur_q <= live - DW'(1);
      else if (ctrl_q.oneshot)  cur_q <= cur_q;
      else if (ctrl_q.periodic) cur_q <= back_q;
      else                      cur_q <= '1;
    end
  end

endmodule

// File: rtl/qtmr_irq.sv
`timescale 1ns/1ps
module qtmr_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] expire,
  input  logic           wr_mask,
  input  logic           wr_clr,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] raw_q,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] mis,
  output logic           irq
);

  logic [NCH-1:0] clr_bits;

  assign clr_bits = wr_clr ? wbits : '0;
  assign mis      = raw_q & mask_q;
  assign irq      = |mis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | expire;
      if (wr_mask) mask_q <= wbits;
    end
  end

endmodule

// File: rtl/quad_down_timer.sv
`timescale 1ns/1ps
module quad_down_timer #(
  parameter int NCH  = 4,
  parameter int DW   = 32,
  parameter int AW   = 12,
  parameter int PS_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  import qtmr_pkg::*;

  localparam int BW = AW - 4;

  logic                     wr;
  logic [BW-1:0]            blk;
  logic [1:0]               word;
  logic                     sh_hit;
  logic [NCH-1:0]           ch_hit;
  logic [NCH-1:0]           expire;
  logic [NCH-1:0]           raw_q;
  logic [NCH-1:0]           mask_q;
  logic [NCH-1:0]           mis;
  logic [NCH-1:0][DW-1:0]   start_w;
  logic [NCH-1:0][DW-1:0]   back_w;
  logic [NCH-1:0][DW-1:0]   view_w;
  logic [NCH-1:0][DW-1:0]   ch_rd;
  ctrl_t [NCH-1:0]          ctrl_w;

  assign wr     = bus_sel && bus_wr;
  assign blk    = bus_addr[AW-1:4];
  assign word   = bus_addr[3:2];
  assign sh_hit = (blk == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_hit[g] = (blk == BW'(g + 1));

    qtmr_channel #(.DW(DW), .PS_W(PS_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .wr_start (wr && ch_hit[g] && (word == CW_START)),
      .wr_ctrl  (wr && ch_hit[g] && (word == CW_CTRL)),
      .wr_back  (wr && ch_hit[g] && (word == CW_BACK)),
      .wdata    (bus_wdata),
      .start_q  (start_w[g]),
      .back_q   (back_w[g]),
      .live     (view_w[g]),
      .ctrl_q   (ctrl_w[g]),
      .expire   (expire[g])
    );

    always_comb begin
      case (word)
        CW_START: ch_rd[g] = start_w[g];
        CW_LIVE:  ch_rd[g] = view_w[g];
        CW_CTRL:  ch_rd[g] = DW'(ctrl_to_word(ctrl_w[g]));
        default:  ch_rd[g] = back_w[g];
      endcase
    end
  end

  qtmr_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .wr_mask (wr && sh_hit && (word == SH_MASK)),
    .wr_clr  (wr && sh_hit && (word == SH_CLR)),
    .wbits   (bus_wdata[NCH-1:0]),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .mis     (mis),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && sh_hit) begin
      case (word)
        SH_MASK: bus_rdata = DW'(mask_q);
        SH_RAW:  bus_rdata = DW'(raw_q);
        SH_MIS:  bus_rdata = DW'(mis);
        default: bus_rdata = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (bus_sel && ch_hit[i]) bus_rdata = ch_rd[i];
    end
  end

endmodule

// File: rtl/quad_down_timer_chk.sv
`timescale 1ns/1ps
module quad_down_timer_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick_en,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [DW-1:0]          bus_rdata,
  input logic                   irq,
  input logic [NCH-1:0]         raw_q,
  input logic [NCH-1:0]         mask_q,
  input logic [NCH-1:0][DW-1:0] view_w,
  input qtmr_pkg::ctrl_t [NCH-1:0] ctrl_w
);
  logic           wr;
  logic [NCH-1:0] en_vec;

  assign wr = bus_sel && bus_wr;

  always_comb begin
    for (int i = 0; i < NCH; i++) en_vec[i] = ctrl_w[i].en;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr) |=> $stable(view_w)); // R4

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0 && !wr) |=> $stable(view_w)); // R4

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((raw_q & $past(raw_q)) == $past(raw_q))); // R10

  AST_RAW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q[0]) |-> (view_w[0] == '0)); // R10

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0 && raw_q != '0)); // R11

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[AW-1:2] == (AW-2)'(5) && !ctrl_w[0].wide)
      |-> (bus_rdata[DW-1:DW/2] == '0)); // R6

  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (view_w[0] == '0 && ctrl_w[0].oneshot && !wr) |=> (view_w[0] == '0)); // R9

endmodule

bind quad_down_timer quad_down_timer_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .raw_q     (raw_q),
  .mask_q    (mask_q),
  .view_w    (view_w),
  .ctrl_w    (ctrl_w)
);

// File: tb/quad_down_timer_tb_top.sv
`timescale 1ns/1ps
module quad_down_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_MASK = 12'h000;
  localparam logic [11:0] A_RAW  = 12'h004;
  localparam logic [11:0] A_MIS  = 12'h008;
  localparam logic [11:0] A_CLR  = 12'h00C;

  always #2.5 clk = ~clk;

  quad_down_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  function automatic logic [11:0] ca(input int n, input int sub);
    return 12'(16 + 16 * n + sub);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    for (int n = 0; n < 4; n++) begin
      for (int s = 0; s < 16; s += 4) rd_chk("R1 reset counter reg", ca(n, s), 32'h0);
    end
    rd_chk("R1 reset mask", A_MASK, 0);
    rd_chk("R1 reset raw", A_RAW, 0);
    rd_chk("R1 reset mis", A_MIS, 0);
    check("R1 reset irq", {31'b0, irq}, 0);
  endtask

  task automatic t_regmap();
    wr_reg(ca(1, 0), 32'h55);
    rd_chk("R2 start readback", ca(1, 0), 32'h55);
    rd_chk("R3 live after load", ca(1, 4), 32'h55);
    wr_reg(ca(1, 12), 32'hA5A5);
    rd_chk("R2 back readback", ca(1, 12), 32'hA5A5);
    wr_reg(ca(1, 8), 32'hFFFF_FFFF);
    rd_chk("R2 ctrl readback drops spare bits", ca(1, 8), 32'hCF);
    wr_reg(ca(1, 8), 32'h0);
    rd_chk("R12 other counter untouched", ca(2, 0), 32'h0);
  endtask

  task automatic t_free32();
    wr_reg(ca(0, 0), 3);
    wr_reg(ca(0, 8), 32'h82);
    ticks(2);
    rd_chk("R4 two decrements", ca(0, 4), 1);
    rd_chk("R10 raw clear before zero", A_RAW, 0);
    ticks(1);
    rd_chk("R4 reaches zero", ca(0, 4), 0);
    rd_chk("R10 raw set at zero", A_RAW, 1);
    ticks(1);
    rd_chk("R7 wrap to max 32", ca(0, 4), 32'hFFFF_FFFF);
    ticks(1);
    rd_chk("R7 keeps counting", ca(0, 4), 32'hFFFF_FFFE);
    rd_chk("R10 raw stays set", A_RAW, 1);
    wr_reg(A_CLR, 1);
    rd_chk("R10 raw cleared by write", A_RAW, 0);
    wr_reg(ca(0, 8), 0);
  endtask

  task automatic t_narrow();
    wr_reg(ca(0, 0), 32'h1234_0002);
    wr_reg(ca(0, 8), 32'h80);
    rd_chk("R6 narrow view", ca(0, 4), 32'h2);
    ticks(3);
    rd_chk("R6 narrow wrap", ca(0, 4), 32'h0000_FFFF);
    wr_reg(A_CLR, 1);
    wr_reg(ca(0, 8), 0);
  endtask

  task automatic t_periodic();
    wr_reg(ca(2, 0), 2);
    wr_reg(ca(2, 12), 7);
    wr_reg(ca(2, 8), 32'hC2);
    ticks(2);
    rd_chk("R8 zero", ca(2, 4), 0);
    rd_chk("R10 raw bit2", A_RAW, 4);
    ticks(1);
    rd_chk("R8 reload from back", ca(2, 4), 7);
    wr_reg(ca(2, 12), 9);
    rd_chk("R8 back write no disturb", ca(2, 4), 7);
    ticks(7);
    rd_chk("R8 zero again", ca(2, 4), 0);
    ticks(1);
    rd_chk("R8 new back value used", ca(2, 4), 9);
    wr_reg(A_CLR, 4);
    wr_reg(ca(2, 8), 0);
  endtask

  task automatic t_oneshot();
    wr_reg(ca(3, 0), 2);
    wr_reg(ca(3, 8), 32'hC3);
    ticks(2);
    rd_chk("R9 zero", ca(3, 4), 0);
    rd_chk("R10 raw bit3", A_RAW, 8);
    wr_reg(A_CLR, 8);
    ticks(5);
    rd_chk("R9 parked at zero", ca(3, 4), 0);
    rd_chk("R9 no further event", A_RAW, 0);
    wr_reg(ca(3, 8), 0);
  endtask

  task automatic t_prescale();
    wr_reg(ca(1, 0), 10);
    wr_reg(ca(1, 8), 32'h86);
    ticks(15);
    rd_chk("R5 div16 not yet", ca(1, 4), 10);
    ticks(1);
    rd_chk("R5 div16 step", ca(1, 4), 9);
    ticks(10);
    wr_reg(ca(1, 0), 10);
    ticks(15);
    rd_chk("R3 phase restarted", ca(1, 4), 10);
    ticks(1);
    rd_chk("R3 step after full period", ca(1, 4), 9);
    wr_reg(ca(1, 8), 32'h8A);
    ticks(255);
    rd_chk("R5 div256 not yet", ca(1, 4), 9);
    ticks(1);
    rd_chk("R5 div256 step", ca(1, 4), 8);
    wr_reg(ca(1, 8), 32'h8E);
    ticks(255);
    rd_chk("R5 code11 not yet", ca(1, 4), 8);
    ticks(1);
    rd_chk("R5 code11 step", ca(1, 4), 7);
    wr_reg(ca(1, 8), 0);
  endtask

  task automatic t_hold();
    wr_reg(ca(0, 0), 5);
    wr_reg(ca(0, 8), 32'h82);
    repeat (10) @(negedge clk);
    rd_chk("R4 no tick no count", ca(0, 4), 5);
    ticks(2);
    rd_chk("R4 counts with tick", ca(0, 4), 3);
    wr_reg(ca(0, 8), 32'h02);
    ticks(4);
    rd_chk("R4 disabled holds", ca(0, 4), 3);
  endtask

  task automatic t_indep();
    wr_reg(ca(0, 0), 4);
    wr_reg(ca(2, 0), 4);
    wr_reg(ca(0, 8), 32'h82);
    wr_reg(ca(2, 8), 32'h02);
    ticks(2);
    rd_chk("R12 enabled counter moves", ca(0, 4), 2);
    rd_chk("R12 disabled neighbour holds", ca(2, 4), 4);
    wr_reg(ca(0, 8), 0);
    wr_reg(ca(2, 8), 0);
  endtask

  task automatic t_irq();
    wr_reg(A_CLR, 32'hF);
    wr_reg(A_MASK, 0);
    wr_reg(ca(0, 0), 1);
    wr_reg(ca(0, 8), 32'h82);
    ticks(1);
    rd_chk("R10 raw set", A_RAW, 1);
    rd_chk("R11 mis masked off", A_MIS, 0);
    check("R11 irq low when masked", {31'b0, irq}, 0);
    wr_reg(A_MASK, 1);
    rd_chk("R2 mask readback", A_MASK, 1);
    rd_chk("R11 mis", A_MIS, 1);
    check("R11 irq high", {31'b0, irq}, 1);
    wr_reg(A_RAW, 0);
    wr_reg(A_MIS, 0);
    rd_chk("R2 raw write ignored", A_RAW, 1);
    wr_reg(A_CLR, 2);
    rd_chk("R10 other clear bit no effect", A_RAW, 1);
    wr_reg(A_CLR, 1);
    rd_chk("R10 cleared", A_RAW, 0);
    check("R11 irq drops", {31'b0, irq}, 0);
    wr_reg(ca(0, 0), 1);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 1; tick_en = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
    rd_chk("R10 set wins over clear", A_RAW, 1);
    rd_chk("R10 count at zero", ca(0, 4), 0);
    wr_reg(A_CLR, 1);
    wr_reg(ca(0, 8), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_free32();
    t_narrow();
    t_periodic();
    t_oneshot();
    t_prescale();
    t_hold();
    t_indep();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule